// File: doc/BRIEF.md
# In-System Programming Stage Sequencer

This controller takes a nonvolatile logic device through a complete in-system programming session. It works over a serial test-access link, which is reached through a request/acknowledge shift engine. A start command launches a session. The session is either a full program run or a verify-only run, selected by a mode input. The address count and a prescaler that scales every millisecond interval into clock cycles are latched at the start.

A full run has six fixed stages: enter, ID check, bulk erase, program, verify and exit. A verify-only run leaves out erase and program. The enter and exit stages are timed settling waits for the pins. Bulk erase is a single long erase pulse. Program and verify step through every address in ascending order, and each address is followed by a short pulse. In the verify stage, read-back data is compared with the expected word on the data port.

The block reports completion, a fail flag, the stage code of the first failure and the first failing address. An ID mismatch cuts the run short and goes straight to the exit stage. A verify miscompare is logged, and the remaining addresses are still checked.

Top module: `isp_stage_seq`

## Requirements
- R1: A full run issues shift operations in this order: ID read (op 1), erase (op 2), program (op 3) for addresses 0..N-1, then a verify-address (op 4) / verify-read (op 5) pair for each address 0..N-1. The program data equals `exp_data_i` for the address being driven.
- R2: A verify-only run issues an ID read and then the verify-address/verify-read pairs for addresses 0..N-1. It never issues erase or program.
- R3: The ID request appears ENTER_MS×prescale cycles after the start is accepted. A prescale of 0 counts as 1.
- R4: After the erase handshake the block waits ERASE_MS×prescale cycles before its next request.
- R5: `done_o` rises EXIT_MS×prescale cycles after the final handshake of the run.
- R6: After each program or verify-address handshake the block waits PULSE_CYC cycles before the next request.
- R7: An ID mismatch issues no further operations, sets `fail_o`, and sets stage code 2. The run still goes through the exit wait to done.
- R8: The first verify miscompare sets `fail_o`, sets stage code 5 and latches its address. All remaining addresses are still verified.
- R9: A run with no mismatch ends with `done_o`=1, `fail_o`=0 and stage code 0.
- R10: A start pulse that arrives while a run is busy is ignored.
- R11: `done_o` and the results hold until the next start. That start clears done and fail.
- R12: An address count of 0 skips the program and verify loops.
- R13: A request holds its opcode and address steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start command pulse |
| verify_only_i | input | 1 | 1 selects a verify-only run |
| addr_count_i | input | AW | Number of addresses to process |
| prescale_i | input | PW | Clock cycles per millisecond |
| sh_req_o | output | 1 | Shift engine request |
| sh_op_o | output | 3 | Operation code of the request |
| sh_addr_o | output | AW | Address of the request |
| sh_wdata_o | output | DW | Program data sent with the request |
| sh_ack_i | input | 1 | Shift engine acknowledge |
| sh_rdata_i | input | DW | Read data valid with the acknowledge |
| exp_data_i | input | DW | Expected content for `sh_addr_o` |
| id_expect_i | input | DW | Expected silicon ID |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Run failed |
| fail_stage_o | output | 3 | Stage code of the first failure |
| fail_addr_o | output | AW | First miscompared address |

## Verification
The assertions assume that `sh_rdata_i` is valid in the same cycle that `sh_ack_i` is high. They also assume that `exp_data_i` follows `sh_addr_o` combinationally, and that acknowledge is only given while a request is pending. The bench's shift-engine model meets these assumptions: it raises acknowledge one cycle after it sees a request and drops it at the handshake. It derives read data and expected data from the driven address with the same content function, and it flips bits only at the chosen bad addresses. Start pulses are driven between clock edges and last one cycle.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ID_RD = 3'd1,
    OP_ERASE = 3'd2,
    OP_PROG  = 3'd3,
    OP_VADDR = 3'd4,
    OP_VREAD = 3'd5
  } isp_op_e;

  typedef enum logic [2:0] {
    STG_NONE   = 3'd0,
    STG_ENTER  = 3'd1,
    STG_ID     = 3'd2,
    STG_ERASE  = 3'd3,
    STG_PROG   = 3'd4,
    STG_VERIFY = 3'd5,
    STG_EXIT   = 3'd6
  } isp_stage_e;

  // Interval length in cycles; a zero prescale behaves as one.
  function automatic logic [31:0] ms_to_cycles(input logic [31:0] ms,
                                               input logic [31:0] pre);
    logic [31:0] p;
    p = (pre == 32'd0) ? 32'd1 : pre;
    return ms * p;
  endfunction

endpackage

// File: rtl/isp_interval_timer.sv
module isp_interval_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= (len_i == '0) ? '0 : len_i - TW'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired_o = run_q && (cnt_q == '0);

  AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o && !load_i |=> !expired_o); // R3

endmodule

// File: rtl/isp_addr_walker.sv
module isp_addr_walker #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [AW-1:0] count_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          empty_o
);

  function automatic logic addr_is_last(input logic [AW-1:0] a,
                                        input logic [AW-1:0] n);
    return (n != '0) && (a == n - AW'(1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_o <= '0;
    else if (clear_i) addr_o <= '0;
    else if (step_i)  addr_o <= addr_o + AW'(1);
  end

  assign last_o  = addr_is_last(addr_o, count_i);
  assign empty_o = (count_i == '0);

  AST_NO_STEP_PAST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !last_o && !empty_o); // R1

endmodule

// File: rtl/isp_result_log.sv
module isp_result_log import isp_seq_pkg::*; #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          id_fail_i,
  input  logic          vfy_miss_i,
  input  logic [AW-1:0] addr_i,
  output logic          fail_o,
  output logic [2:0]    stage_o,
  output logic [AW-1:0] fail_addr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_o      <= 1'b0;
      stage_o     <= STG_NONE;
      fail_addr_o <= '0;
    end else if (clear_i) begin
      fail_o      <= 1'b0;
      stage_o     <= STG_NONE;
      fail_addr_o <= '0;
    end else if (id_fail_i) begin
      fail_o  <= 1'b1;
      stage_o <= STG_ID;
    end else if (vfy_miss_i && !fail_o) begin
      fail_o      <= 1'b1;
      stage_o     <= STG_VERIFY;
      fail_addr_o <= addr_i;
    end
  end

  AST_FIRST_MISS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o && !clear_i |=> fail_o && $stable(fail_addr_o) && $stable(stage_o)); // R8

endmodule

// File: rtl/isp_stage_seq.sv
module isp_stage_seq import isp_seq_pkg::*; #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int PW        = 16,
  parameter int TW        = 32,
  parameter int ENTER_MS  = 1,
  parameter int EXIT_MS   = 1,
  parameter int ERASE_MS  = 100,
  parameter int PULSE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          verify_only_i,
  input  logic [AW-1:0] addr_count_i,
  input  logic [PW-1:0] prescale_i,
  output logic          sh_req_o,
  output logic [2:0]    sh_op_o,
  output logic [AW-1:0] sh_addr_o,
  output logic [DW-1:0] sh_wdata_o,
  input  logic          sh_ack_i,
  input  logic [DW-1:0] sh_rdata_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [DW-1:0] id_expect_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [2:0]    fail_stage_o,
  output logic [AW-1:0] fail_addr_o
);

  typedef enum logic [3:0] {
    S_IDLE, S_ENTER, S_ID, S_ERASE_SH, S_ERASE_W, S_PROG_SH, S_PROG_W,
    S_VADDR_SH, S_VPULSE, S_VREAD_SH, S_EXIT, S_DONE
  } st_e;

  st_e           st_q, st_d;
  logic          vonly_q;
  logic [AW-1:0] cnt_q;
  logic [PW-1:0] pre_q;

  // named internal events
  logic          start_go, hs, id_ok, data_ok;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_len;
  logic          wk_clear, wk_step, wk_last, wk_empty;
  logic          id_fail, vfy_miss, res_clear;
  logic [TW-1:0] len_enter, len_exit, len_erase, len_pulse;

  assign start_go  = start_i && (st_q == S_IDLE || st_q == S_DONE);
  assign hs        = sh_req_o && sh_ack_i;
  assign id_ok     = (sh_rdata_i == id_expect_i);
  assign data_ok   = (sh_rdata_i == exp_data_i);
  assign len_enter = TW'(ms_to_cycles(32'(ENTER_MS), 32'(prescale_i)));
  assign len_exit  = TW'(ms_to_cycles(32'(EXIT_MS), 32'(pre_q)));
  assign len_erase = TW'(ms_to_cycles(32'(ERASE_MS), 32'(pre_q)));
  assign len_pulse = TW'(PULSE_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      vonly_q <= 1'b0;
      cnt_q   <= '0;
      pre_q   <= '0;
    end else begin
      st_q <= st_d;
      if (start_go) begin
        vonly_q <= verify_only_i;
        cnt_q   <= addr_count_i;
        pre_q   <= prescale_i;
      end
    end
  end

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_len   = '0;
    wk_clear  = 1'b0;
    wk_step   = 1'b0;
    id_fail   = 1'b0;
    vfy_miss  = 1'b0;
    res_clear = 1'b0;
    case (st_q)
      S_IDLE, S_DONE: if (start_i) begin
        st_d = S_ENTER; tmr_load = 1'b1; tmr_len = len_enter;
        wk_clear = 1'b1; res_clear = 1'b1;
      end
      S_ENTER: if (tmr_exp) st_d = S_ID;
      S_ID: if (hs) begin
        if (!id_ok) begin
          id_fail = 1'b1; st_d = S_EXIT; tmr_load = 1'b1; tmr_len = len_exit;
        end else if (!vonly_q) begin
          st_d = S_ERASE_SH;
        end else if (wk_empty) begin
          st_d = S_EXIT; tmr_load = 1'b1; tmr_len = len_exit;
        end else begin
          st_d = S_VADDR_SH;
        end
      end
      S_ERASE_SH: if (hs) begin
        st_d = S_ERASE_W; tmr_load = 1'b1; tmr_len = len_erase;
      end
      S_ERASE_W: if (tmr_exp) begin
        if (wk_empty) begin
          st_d = S_EXIT; tmr_load = 1'b1; tmr_len = len_exit;
        end else begin
          st_d = S_PROG_SH;
        end
      end
      S_PROG_SH: if (hs) begin
        st_d = S_PROG_W; tmr_load = 1'b1; tmr_len = len_pulse;
      end
      S_PROG_W: if (tmr_exp) begin
        if (wk_last) begin wk_clear = 1'b1; st_d = S_VADDR_SH; end
        else         begin wk_step  = 1'b1; st_d = S_PROG_SH;  end
      end
      S_VADDR_SH: if (hs) begin
        st_d = S_VPULSE; tmr_load = 1'b1; tmr_len = len_pulse;
      end
      S_VPULSE: if (tmr_exp) st_d = S_VREAD_SH;
      S_VREAD_SH: if (hs) begin
        vfy_miss = !data_ok;
        if (wk_last) begin
          st_d = S_EXIT; tmr_load = 1'b1; tmr_len = len_exit;
        end else begin
          wk_step = 1'b1; st_d = S_VADDR_SH;
        end
      end
      S_EXIT: if (tmr_exp) st_d = S_DONE;
      default: st_d = S_IDLE;
    endcase
  end

  isp_interval_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .len_i(tmr_len),
    .expired_o(tmr_exp)
  );

  isp_addr_walker #(.AW(AW)) u_walker (
    .clk(clk), .rst_n(rst_n), .clear_i(wk_clear), .step_i(wk_step),
    .count_i(cnt_q), .addr_o(sh_addr_o), .last_o(wk_last), .empty_o(wk_empty)
  );

  isp_result_log #(.AW(AW)) u_result (
    .clk(clk), .rst_n(rst_n), .clear_i(res_clear), .id_fail_i(id_fail),
    .vfy_miss_i(vfy_miss), .addr_i(sh_addr_o), .fail_o(fail_o),
    .stage_o(fail_stage_o), .fail_addr_o(fail_addr_o)
  );

  always_comb begin
    case (st_q)
      S_ID:       sh_op_o = OP_ID_RD;
      S_ERASE_SH: sh_op_o = OP_ERASE;
      S_PROG_SH:  sh_op_o = OP_PROG;
      S_VADDR_SH: sh_op_o = OP_VADDR;
      S_VREAD_SH: sh_op_o = OP_VREAD;
      default:    sh_op_o = OP_NONE;
    endcase
  end

  assign sh_req_o   = (sh_op_o != OP_NONE);
  assign sh_wdata_o = exp_data_i;
  assign busy_o     = (st_q != S_IDLE) && (st_q != S_DONE);
  assign done_o     = (st_q == S_DONE);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req_o && !sh_ack_i |=> sh_req_o && $stable(sh_op_o) && $stable(sh_addr_o)); // R13
  AST_VONLY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req_o && vonly_q |-> sh_op_o != OP_ERASE && sh_op_o != OP_PROG); // R2
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req_o && sh_op_o >= OP_PROG |-> sh_addr_o < cnt_q); // R1
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(fail_o)); // R11
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(cnt_q) && $stable(vonly_q) && $stable(pre_q)); // R10
  AST_ID_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    fail_stage_o == STG_ID |-> !(sh_req_o && sh_op_o != OP_ID_RD)); // R7

endmodule

// File: tb/isp_stage_seq_bench.sv
module isp_stage_seq_bench;

  localparam int AW = 8, DW = 16, PW = 16, TW = 32;
  localparam int ENTER_MS = 1, EXIT_MS = 1, ERASE_MS = 100, PULSE_CYC = 4;
  localparam logic [DW-1:0] ID_GOOD = 16'h5A3C;
  localparam logic [AW-1:0] NONE = 8'hFF;

  typedef struct packed {
    logic          vonly;
    logic [AW-1:0] n;
    logic [PW-1:0] pre;
    logic [AW-1:0] bad1;
    logic [AW-1:0] bad2;
    logic          idbad;
    logic          xfail;
    logic [2:0]    xstage;
    logic [AW-1:0] xaddr;
    logic [7:0]    xops;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 8'd4, 16'd3, NONE,  NONE,  1'b0, 1'b0, 3'd0, 8'd0, 8'd14},
    '{1'b1, 8'd5, 16'd2, 8'd3,  NONE,  1'b0, 1'b1, 3'd5, 8'd3, 8'd11},
    '{1'b0, 8'd6, 16'd1, 8'd1,  8'd4,  1'b0, 1'b1, 3'd5, 8'd1, 8'd20},
    '{1'b0, 8'd3, 16'd2, NONE,  NONE,  1'b1, 1'b1, 3'd2, 8'd0, 8'd1},
    '{1'b0, 8'd0, 16'd0, NONE,  NONE,  1'b0, 1'b0, 3'd0, 8'd0, 8'd2},
    '{1'b1, 8'd1, 16'd4, 8'd0,  NONE,  1'b0, 1'b1, 3'd5, 8'd0, 8'd3},
    '{1'b1, 8'd0, 16'd1, NONE,  NONE,  1'b0, 1'b0, 3'd0, 8'd0, 8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, vonly = 1'b0, ack = 1'b0;
  logic [AW-1:0] n_cfg = '0, bad1 = NONE, bad2 = NONE;
  logic [PW-1:0] pre_cfg = '0;
  logic [DW-1:0] id_val = ID_GOOD;
  logic          req, busy, done, fail;
  logic [2:0]    op, fstage;
  logic [AW-1:0] addr, faddr;
  logic [DW-1:0] wdata, rdata, expd;

  int nchk = 0, nfail = 0, cyc = 0, start_cyc = 0, done_cyc = 0, nlog = 0;
  logic done_q = 1'b0;
  int lop [64], laddr [64], lwd [64], lcyc [64];

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] golden(input logic [AW-1:0] a);
    return DW'(a) * 16'd37 + 16'd5;
  endfunction

  assign expd  = golden(addr);
  assign rdata = (op == 3'd1) ? id_val
               : (golden(addr) ^ ((addr == bad1 || addr == bad2) ? 16'h0001 : 16'h0000));

  isp_stage_seq #(.AW(AW), .DW(DW), .PW(PW), .TW(TW), .ENTER_MS(ENTER_MS),
    .EXIT_MS(EXIT_MS), .ERASE_MS(ERASE_MS), .PULSE_CYC(PULSE_CYC)) u_isp_stage_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .verify_only_i(vonly),
    .addr_count_i(n_cfg), .prescale_i(pre_cfg), .sh_req_o(req), .sh_op_o(op),
    .sh_addr_o(addr), .sh_wdata_o(wdata), .sh_ack_i(ack), .sh_rdata_i(rdata),
    .exp_data_i(expd), .id_expect_i(ID_GOOD), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_stage_o(fstage), .fail_addr_o(faddr)
  );

  // shift engine model and handshake logger
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (rst_n) begin
        if (start && !busy) start_cyc = cyc;
        if (req && ack && nlog < 64) begin
          lop[nlog] = int'(op); laddr[nlog] = int'(addr);
          lwd[nlog] = int'(wdata); lcyc[nlog] = cyc; nlog++;
        end
        if (done && !done_q) done_cyc = cyc - 1;
        done_q = done;
      end
      ack <= rst_n && req && !ack;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 5000) begin @(negedge clk); k++; end
    chk(done, "R5", "run reached done", longint'(done), 1);
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    vonly = v.vonly; n_cfg = v.n; pre_cfg = v.pre; bad1 = v.bad1; bad2 = v.bad2;
    id_val = v.idbad ? 16'hDEAD : ID_GOOD;
    nlog = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_run(input vec_t v);
    int eop [64], ea [64];
    int ne = 0, pe, bad_seq = 0, bad_gap = 0, bad_wd = 0;
    string tseq;
    pe = (v.pre == 0) ? 1 : int'(v.pre);
    eop[ne] = 1; ea[ne] = 0; ne++;
    if (!v.idbad) begin
      if (!v.vonly) begin
        eop[ne] = 2; ea[ne] = 0; ne++;
        for (int a = 0; a < int'(v.n); a++) begin eop[ne] = 3; ea[ne] = a; ne++; end
      end
      for (int a = 0; a < int'(v.n); a++) begin
        eop[ne] = 4; ea[ne] = a; ne++;
        eop[ne] = 5; ea[ne] = a; ne++;
      end
    end
    tseq = (v.n == 0) ? "R12" : (v.idbad ? "R7" : (v.vonly ? "R2" : "R1"));
    chk(nlog == ne && nlog == int'(v.xops), tseq, "operation count", nlog, ne);
    for (int k = 0; k < ne && k < nlog; k++) begin
      if (lop[k] != eop[k] || (eop[k] >= 3 && laddr[k] != ea[k])) bad_seq++;
      if (lop[k] == 3 && lwd[k] != int'(golden(AW'(laddr[k])))) bad_wd++;
      if ((lop[k] == 3 || lop[k] == 4) && k + 1 < nlog &&
          lcyc[k+1] - lcyc[k] != PULSE_CYC + 2) bad_gap++;
    end
    chk(bad_seq == 0, tseq, "operation order mismatches", bad_seq, 0);
    chk(bad_wd == 0, "R1", "program data mismatches", bad_wd, 0);
    chk(bad_gap == 0, "R6", "pulse gap mismatches", bad_gap, 0);
    if (nlog > 0) begin
      chk(lcyc[0] - start_cyc == ENTER_MS * pe + 2, "R3", "start to ID handshake",
          lcyc[0] - start_cyc, ENTER_MS * pe + 2);
      if (!(v.n == 0 && !v.vonly && !v.idbad))
        chk(done_cyc - lcyc[nlog-1] == EXIT_MS * pe, "R5", "exit interval",
            done_cyc - lcyc[nlog-1], EXIT_MS * pe);
    end
    if (!v.vonly && !v.idbad && v.n != 0 && nlog > 2)
      chk(lcyc[2] - lcyc[1] == ERASE_MS * pe + 2, "R4", "erase interval",
          lcyc[2] - lcyc[1], ERASE_MS * pe + 2);
    if (!v.vonly && !v.idbad && v.n == 0 && nlog > 1)
      chk(done_cyc - lcyc[1] == (ERASE_MS + EXIT_MS) * pe, "R12", "erase then exit",
          done_cyc - lcyc[1], (ERASE_MS + EXIT_MS) * pe);
    chk(fail == v.xfail, v.xfail ? (v.idbad ? "R7" : "R8") : "R9", "fail flag",
        longint'(fail), longint'(v.xfail));
    chk(fstage == v.xstage, v.idbad ? "R7" : "R8", "fail stage",
        longint'(fstage), longint'(v.xstage));
    if (v.xfail && !v.idbad)
      chk(faddr == v.xaddr, "R8", "first failing address", longint'(faddr), longint'(v.xaddr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req && !busy && !done && !fail, "R9", "reset state idle",
        longint'({req, busy, done, fail}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      launch(VECS[i]);
      wait_done();
      repeat (2) @(negedge clk);
      check_run(VECS[i]);
    end

    // done holds until the next start
    begin
      logic fl; logic [AW-1:0] fa;
      fl = fail; fa = faddr;
      repeat (25) @(negedge clk);
      chk(done && fail == fl && faddr == fa, "R11", "done and results held",
          longint'({done, fail}), longint'({1'b1, fl}));
    end

    // a new start clears done and fail
    launch(VECS[0]);
    chk(!done && !fail && busy, "R11", "start clears results",
        longint'({done, fail, busy}), 1);

    // start while busy is ignored
    repeat (40) @(negedge clk);
    vonly = 1'b1; n_cfg = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (2) @(negedge clk);
    chk(nlog == 14, "R10", "mid-run start ignored, op count", nlog, 14);
    chk(!fail, "R10", "mid-run start ignored, result", longint'(fail), 0);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule